// File: doc/BRIEF.md
# Software Trap and Interrupt-Return Sequencer

This block carries out the vectored trap instructions of a 16-bit segmented processor, and the matching return from interrupt, as a multi-cycle sequence. The front end has already fetched the instruction. It hands over the opcode byte, an optional second opcode byte, an optional immediate byte, the current program counter, code segment, flag word and stack pointer, the overflow flag, and the two results of a bounds comparison. It then pulses `start`.

For a trap that is taken, the sequencer first reads the new offset and then the new segment from a four-byte slot in the low-memory vector table. It pushes the flag word, the segment and the return address onto the stack. It then loads the new program counter, segment, flags and stack pointer. The return instruction pops the three words back. The block uses a single 16-bit word port with a request/acknowledge handshake and keeps at most one access outstanding. Addresses on that port are flat byte addresses, and forming the physical address is left to the caller.

The four register outputs change together, and only in the cycle in which `done` is high. If a conditional trap does not fire, or the opcode is not recognised, the block completes without touching memory and returns the input register values unchanged.

Top module: `trap_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are 0, and `pc_out`, `ps_out`, `psw_out` and `sp_out` are 0.
- R2: A taken trap with vector n reads the offset word at byte address 4n and then the segment word at 4n+2. The vector is selected by the opcode: 0xCC uses n=3; 0xCD uses n=`imm`; 0xCE uses n=4; 0x62 uses n=5; 0x0F with `ext`=0xFF uses n=`imm`.
- R3: After the two vector reads, a taken trap writes three words in this order: the original flag word at SP-2, the code segment at SP-4, and `pc_in` (the return address) at SP-6.
- R4: When a trap completes, `pc_out` equals the offset that was read, `ps_out` equals the segment that was read, and `sp_out` equals SP-6, computed modulo 2^16.
- R5: For opcodes 0xCC, 0xCD, 0xCE and 0x62, `psw_out` is the input flag word with bit 9 (interrupt enable) and bit 8 (single step) cleared. All other bits are kept.
- R6: For 0x0F 0xFF, `psw_out` is the input flag word with bit 15 (mode flag) cleared. Bits 9 and 8 are kept.
- R7: Opcode 0xCE with `v_flag`=0, and opcode 0x62 with both bound flags at 0, make no memory access. For these cases the outputs equal the register inputs.
- R8: Opcode 0xCF reads `pc_out` from SP, `ps_out` from SP+2 and `psw_out` from SP+4, in that order. It makes no write and sets `sp_out` to SP+6.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable. Each acknowledge completes exactly one access.
- R10: `done` is a one-cycle pulse. The register outputs change only while `done` is high. A `start` pulse that arrives while `busy` is high is ignored.
- R11: Any other opcode, including 0x0F followed by a byte other than 0xFF, completes with no memory access and leaves the outputs equal to the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction; sampled only when idle |
| opc | input | 8 | First opcode byte |
| ext | input | 8 | Second opcode byte (used after 0x0F) |
| imm | input | 8 | Immediate vector number |
| v_flag | input | 1 | Overflow flag for the conditional trap |
| bnd_lo | input | 1 | Register value is below the lower bound |
| bnd_hi | input | 1 | Register value is above the upper bound |
| pc_in | input | 16 | Return address (instruction after the trap) |
| ps_in | input | 16 | Current code segment |
| psw_in | input | 16 | Current flag word |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| ps_out | output | 16 | Resulting code segment |
| psw_out | output | 16 | Resulting flag word |
| sp_out | output | 16 | Resulting stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |

## Verification
A wrong sequencer state shows up at the memory port straight away. The access that follows has the wrong address, the wrong direction or the wrong data, and the reference model catches it at the first acknowledge. A captured register or vector word that is corrupted inside the block stays hidden until completion, and then appears in the one cycle where `done` is high as a wrong `pc_out`, `ps_out`, `psw_out` or `sp_out`. Between instructions, any spurious change of an output is flagged in the very cycle it happens.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
    parameter int unsigned WORD_W = 16;
    parameter int unsigned OPC_W  = 8;
    parameter int unsigned VEC_W  = 8;

    localparam logic [OPC_W-1:0] OPC_BRK = 8'hCC;
    localparam logic [OPC_W-1:0] OPC_INT = 8'hCD;
    localparam logic [OPC_W-1:0] OPC_OVF = 8'hCE;
    localparam logic [OPC_W-1:0] OPC_RET = 8'hCF;
    localparam logic [OPC_W-1:0] OPC_BND = 8'h62;
    localparam logic [OPC_W-1:0] OPC_ESC = 8'h0F;
    localparam logic [OPC_W-1:0] OPC_EMU = 8'hFF;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_TRAP,
        OP_EMU,
        OP_RET
    } op_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_OFS,
        ST_RD_SEG,
        ST_PUSH_FLG,
        ST_PUSH_SEG,
        ST_PUSH_RET,
        ST_POP_RET,
        ST_POP_SEG,
        ST_POP_FLG
    } seq_state_e;

    typedef struct packed {
        seq_state_e        st;
        op_kind_e          kind;
        logic [WORD_W-1:0] vbase;
        logic [WORD_W-1:0] ofs;
        logic [WORD_W-1:0] seg;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ps;
        logic [WORD_W-1:0] psw;
        logic [WORD_W-1:0] sp;
        logic              done;
        logic [WORD_W-1:0] pc_o;
        logic [WORD_W-1:0] ps_o;
        logic [WORD_W-1:0] psw_o;
        logic [WORD_W-1:0] sp_o;
    } seq_regs_t;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
    import trap_seq_pkg::*;
#(
    parameter int unsigned BRK_VEC = 3,
    parameter int unsigned OVF_VEC = 4,
    parameter int unsigned BND_VEC = 5
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [OPC_W-1:0] ext,
    input  logic [VEC_W-1:0] imm,
    input  logic             v_flag,
    input  logic             bnd_lo,
    input  logic             bnd_hi,
    output op_kind_e         kind,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        kind = OP_NONE;
        vec  = imm;
        case (opc)
            OPC_BRK: begin
                kind = OP_TRAP;
                vec  = VEC_W'(BRK_VEC);
            end
            OPC_INT: kind = OP_TRAP;
            OPC_OVF: begin
                vec = VEC_W'(OVF_VEC);
                if (v_flag) kind = OP_TRAP;
            end
            OPC_BND: begin
                vec = VEC_W'(BND_VEC);
                if (bnd_lo || bnd_hi) kind = OP_TRAP;
            end
            OPC_ESC: begin
                if (ext == OPC_EMU) kind = OP_EMU;
            end
            OPC_RET: kind = OP_RET;
            default: kind = OP_NONE;
        endcase
    end
endmodule

// File: rtl/trap_flag_edit.sv
module trap_flag_edit
    import trap_seq_pkg::*;
#(
    parameter int unsigned IE_BIT  = 9,
    parameter int unsigned BRK_BIT = 8,
    parameter int unsigned MD_BIT  = 15
) (
    input  op_kind_e          kind,
    input  logic [WORD_W-1:0] psw_in,
    output logic [WORD_W-1:0] psw_new
);
    always_comb begin
        psw_new = psw_in;
        if (kind == OP_TRAP) begin
            psw_new[IE_BIT]  = 1'b0;
            psw_new[BRK_BIT] = 1'b0;
        end else if (kind == OP_EMU) begin
            psw_new[MD_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int unsigned BRK_VEC = 3,
    parameter int unsigned OVF_VEC = 4,
    parameter int unsigned BND_VEC = 5,
    parameter int unsigned IE_BIT  = 9,
    parameter int unsigned BRK_BIT = 8,
    parameter int unsigned MD_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPC_W-1:0]  opc,
    input  logic [OPC_W-1:0]  ext,
    input  logic [VEC_W-1:0]  imm,
    input  logic              v_flag,
    input  logic              bnd_lo,
    input  logic              bnd_hi,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] ps_in,
    input  logic [WORD_W-1:0] psw_in,
    input  logic [WORD_W-1:0] sp_in,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] ps_out,
    output logic [WORD_W-1:0] psw_out,
    output logic [WORD_W-1:0] sp_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int unsigned WORD_BYTES  = WORD_W / 8;
    localparam int unsigned SLOT_SHIFT  = $clog2(2 * WORD_BYTES);
    localparam int unsigned FRAME_BYTES = 3 * WORD_BYTES;

    localparam logic [WORD_W-1:0] STEP  = WORD_W'(WORD_BYTES);
    localparam logic [WORD_W-1:0] FRAME = WORD_W'(FRAME_BYTES);

    seq_regs_t         q, d;
    op_kind_e          dec_kind;
    logic [VEC_W-1:0]  dec_vec;
    logic [WORD_W-1:0] psw_new;

    trap_decode #(
        .BRK_VEC (BRK_VEC),
        .OVF_VEC (OVF_VEC),
        .BND_VEC (BND_VEC)
    ) u_dec (
        .opc    (opc),
        .ext    (ext),
        .imm    (imm),
        .v_flag (v_flag),
        .bnd_lo (bnd_lo),
        .bnd_hi (bnd_hi),
        .kind   (dec_kind),
        .vec    (dec_vec)
    );

    trap_flag_edit #(
        .IE_BIT  (IE_BIT),
        .BRK_BIT (BRK_BIT),
        .MD_BIT  (MD_BIT)
    ) u_flag (
        .kind    (q.kind),
        .psw_in  (q.psw),
        .psw_new (psw_new)
    );

    // Memory port: decoded from the current state only
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            ST_RD_OFS:   mem_addr = q.vbase;
            ST_RD_SEG:   mem_addr = q.vbase + STEP;
            ST_PUSH_FLG: begin
                mem_we    = 1'b1;
                mem_addr  = q.sp - STEP;
                mem_wdata = q.psw;
            end
            ST_PUSH_SEG: begin
                mem_we    = 1'b1;
                mem_addr  = q.sp - 2 * STEP;
                mem_wdata = q.ps;
            end
            ST_PUSH_RET: begin
                mem_we    = 1'b1;
                mem_addr  = q.sp - 3 * STEP;
                mem_wdata = q.pc;
            end
            ST_POP_RET:  mem_addr = q.sp;
            ST_POP_SEG:  mem_addr = q.sp + STEP;
            ST_POP_FLG:  mem_addr = q.sp + 2 * STEP;
            default:     mem_req = 1'b0;
        endcase
    end

    // Next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.kind  = dec_kind;
                    d.vbase = WORD_W'(dec_vec) << SLOT_SHIFT;
                    d.pc    = pc_in;
                    d.ps    = ps_in;
                    d.psw   = psw_in;
                    d.sp    = sp_in;
                    case (dec_kind)
                        OP_TRAP, OP_EMU: d.st = ST_RD_OFS;
                        OP_RET:          d.st = ST_POP_RET;
                        default: begin
                            d.done  = 1'b1;
                            d.pc_o  = pc_in;
                            d.ps_o  = ps_in;
                            d.psw_o = psw_in;
                            d.sp_o  = sp_in;
                        end
                    endcase
                end
            end
            ST_RD_OFS: if (mem_ack) begin
                d.ofs = mem_rdata;
                d.st  = ST_RD_SEG;
            end
            ST_RD_SEG: if (mem_ack) begin
                d.seg = mem_rdata;
                d.st  = ST_PUSH_FLG;
            end
            ST_PUSH_FLG: if (mem_ack) d.st = ST_PUSH_SEG;
            ST_PUSH_SEG: if (mem_ack) d.st = ST_PUSH_RET;
            ST_PUSH_RET: if (mem_ack) begin
                d.st    = ST_IDLE;
                d.done  = 1'b1;
                d.pc_o  = q.ofs;
                d.ps_o  = q.seg;
                d.psw_o = psw_new;
                d.sp_o  = q.sp - FRAME;
            end
            ST_POP_RET: if (mem_ack) begin
                d.ofs = mem_rdata;
                d.st  = ST_POP_SEG;
            end
            ST_POP_SEG: if (mem_ack) begin
                d.seg = mem_rdata;
                d.st  = ST_POP_FLG;
            end
            ST_POP_FLG: if (mem_ack) begin
                d.st    = ST_IDLE;
                d.done  = 1'b1;
                d.pc_o  = q.ofs;
                d.ps_o  = q.seg;
                d.psw_o = mem_rdata;
                d.sp_o  = q.sp + FRAME;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = (q.st != ST_IDLE);
    assign done    = q.done;
    assign pc_out  = q.pc_o;
    assign ps_out  = q.ps_o;
    assign psw_out = q.psw_o;
    assign sp_out  = q.sp_o;
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
    import trap_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] pc_out,
    input logic [WORD_W-1:0] sp_out,
    input logic [WORD_W-1:0] psw_out
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_req); // R10
    AST_OUT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(pc_out) && $stable(sp_out) && $stable(psw_out)) |-> done); // R10
endmodule

bind trap_seq trap_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_out    (pc_out),
    .sp_out    (sp_out),
    .psw_out   (psw_out)
);

// File: tb/trap_seq_test.sv
module trap_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opc = '0, ext = '0, imm = '0;
    logic        v_flag = 1'b0, bnd_lo = 1'b0, bnd_hi = 1'b0;
    logic [15:0] pc_in = '0, ps_in = '0, psw_in = '0, sp_in = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] pc_out, ps_out, psw_out, sp_out, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_addr[$];
    logic        exp_we[$];
    logic [15:0] exp_wd[$];
    string       exp_tag[$];

    always #10 clk = ~clk;

    trap_seq uut (.*);

    function automatic logic [15:0] rd_word(input logic [15:0] a);
        return (a * 16'h03B1) ^ 16'h5A0F;
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [15:0] a, input logic we, input logic [15:0] wd, input string tag);
        exp_addr.push_back(a);
        exp_we.push_back(we);
        exp_wd.push_back(wd);
        exp_tag.push_back(tag);
    endtask

    task automatic run_op(input logic [7:0] o, input logic [7:0] e, input logic [7:0] im,
                          input logic v, input logic lo, input logic hi,
                          input logic [15:0] pc, input logic [15:0] ps,
                          input logic [15:0] psw, input logic [15:0] sp, input bit inject);
        int          kind; // 0 none, 1 trap, 2 emu, 3 ret
        logic [15:0] n, epc, eps, epsw, esp, ppc, pps, ppsw, psp, hold_addr;
        string       ftag, ptag;
        int          wait_cnt, cyc;
        bit          fin;
        kind = 0;
        n = {8'h00, im};
        if (o == 8'hCC) begin kind = 1; n = 16'd3; end
        else if (o == 8'hCD) kind = 1;
        else if (o == 8'hCE && v) begin kind = 1; n = 16'd4; end
        else if (o == 8'h62 && (lo || hi)) begin kind = 1; n = 16'd5; end
        else if (o == 8'h0F && e == 8'hFF) kind = 2;
        else if (o == 8'hCF) kind = 3;
        if (kind == 1 || kind == 2) begin
            push_exp(n * 4, 1'b0, 16'h0, "R2");
            push_exp(n * 4 + 2, 1'b0, 16'h0, "R2");
            push_exp(sp - 2, 1'b1, psw, "R3");
            push_exp(sp - 4, 1'b1, ps, "R3");
            push_exp(sp - 6, 1'b1, pc, "R3");
            epc = rd_word(n * 4); eps = rd_word(n * 4 + 2); esp = sp - 6;
            epsw = (kind == 1) ? (psw & ~16'h0300) : (psw & ~16'h8000);
            ftag = "R4"; ptag = (kind == 1) ? "R5" : "R6";
        end else if (kind == 3) begin
            push_exp(sp, 1'b0, 16'h0, "R8");
            push_exp(sp + 2, 1'b0, 16'h0, "R8");
            push_exp(sp + 4, 1'b0, 16'h0, "R8");
            epc = rd_word(sp); eps = rd_word(sp + 2); epsw = rd_word(sp + 4); esp = sp + 6;
            ftag = "R8"; ptag = "R8";
        end else begin
            epc = pc; eps = ps; epsw = psw; esp = sp;
            ftag = (o == 8'hCE || o == 8'h62) ? "R7" : "R11"; ptag = ftag;
        end
        ppc = pc_out; pps = ps_out; ppsw = psw_out; psp = sp_out;
        @(negedge clk);
        opc = o; ext = e; imm = im; v_flag = v; bnd_lo = lo; bnd_hi = hi;
        pc_in = pc; ps_in = ps; psw_in = psw; sp_in = sp; start = 1'b1;
        wait_cnt = 1; cyc = 0; fin = 0; hold_addr = '0;
        while (!fin && cyc < 400) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            mem_ack = 1'b0;
            if (inject && cyc == 2) begin
                start = 1'b1; opc = 8'hCC; sp_in = 16'h1234; pc_in = 16'h4321;
            end
            if (done) begin
                fin = 1;
                chk(ftag, "pc_out", pc_out, epc);
                chk(ftag, "ps_out", ps_out, eps);
                chk(ptag, "psw_out", psw_out, epsw);
                chk(ftag, "sp_out", sp_out, esp);
                chk(ftag, "accesses left", 16'(exp_addr.size()), 16'd0);
            end else begin
                chk("R10", "pc_out held", pc_out, ppc);
                chk("R10", "ps_out held", ps_out, pps);
                chk("R10", "psw_out held", psw_out, ppsw);
                chk("R10", "sp_out held", sp_out, psp);
                if (mem_req) begin
                    if (wait_cnt > 0) begin
                        if (wait_cnt < 2) hold_addr = mem_addr;
                        else chk("R9", "held addr", mem_addr, hold_addr);
                        wait_cnt++;
                        if (wait_cnt > 2 + (cyc % 2)) wait_cnt = 0;
                    end else begin
                        if (exp_addr.size() == 0) begin
                            chk(ftag, "unexpected access", mem_addr, 16'hFFFF);
                        end else begin
                            string t;
                            t = exp_tag.pop_front();
                            chk(t, "mem_addr", mem_addr, exp_addr.pop_front());
                            chk(t, "mem_we", {15'h0, mem_we}, {15'h0, exp_we.pop_front()});
                            if (mem_we) chk(t, "mem_wdata", mem_wdata, exp_wd.pop_front());
                            else void'(exp_wd.pop_front());
                        end
                        mem_ack = 1'b1;
                        mem_rdata = rd_word(mem_addr);
                        wait_cnt = 1;
                    end
                end
            end
        end
        if (!fin) chk("R10", "done never seen", 16'h0, 16'h1);
        exp_addr.delete(); exp_we.delete(); exp_wd.delete(); exp_tag.delete();
        @(negedge clk);
        mem_ack = 1'b0;
        start = 1'b0;
        chk("R10", "done one cycle", {15'h0, done}, 16'h0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL R10 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", {15'h0, busy}, 16'h0);
        chk("R1", "done", {15'h0, done}, 16'h0);
        chk("R1", "mem_req", {15'h0, mem_req}, 16'h0);
        chk("R1", "mem_we", {15'h0, mem_we}, 16'h0);
        chk("R1", "pc_out", pc_out, 16'h0);
        chk("R1", "sp_out", sp_out, 16'h0);
        // R2 R3 R4 R5: fixed breakpoint vector
        run_op(8'hCC, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0102, 16'h2000, 16'hF3FF, 16'h0100, 0);
        // R2: vector from immediate, high number
        run_op(8'hCD, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 16'hABCD, 16'h3000, 16'h0300, 16'h8000, 0);
        // R2 R5: overflow taken
        run_op(8'hCE, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0050, 16'h0010, 16'h0B00, 16'h0200, 0);
        // R7: overflow not taken
        run_op(8'hCE, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0051, 16'h0011, 16'h0300, 16'h0200, 0);
        // R6: emulation entry keeps IE/BRK
        run_op(8'h0F, 8'hFF, 8'h40, 1'b0, 1'b0, 1'b0, 16'h1111, 16'h2222, 16'h8300, 16'h0400, 0);
        // R11: escape without FF
        run_op(8'h0F, 8'h00, 8'h40, 1'b0, 1'b0, 1'b0, 16'h1112, 16'h2223, 16'h8300, 16'h0400, 0);
        // R2: bounds below and above
        run_op(8'h62, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0600, 16'h0700, 16'h0200, 16'h0300, 0);
        run_op(8'h62, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0602, 16'h0702, 16'h0100, 16'h0300, 0);
        // R7: bounds in range
        run_op(8'h62, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0604, 16'h0704, 16'h0300, 16'h0300, 0);
        // R8: return
        run_op(8'hCF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h00FA, 0);
        // R11: unrelated opcode
        run_op(8'h90, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 16'h7777, 16'h6666, 16'h5555, 16'h4444, 0);
        // R10: start while busy ignored
        run_op(8'hCD, 8'h00, 8'h21, 1'b0, 1'b0, 1'b0, 16'h0A0A, 16'h0B0B, 16'hFFFF, 16'h0E00, 1);
        // R4: stack wraps below zero
        run_op(8'hCC, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0020, 16'h0000, 16'h0002, 0);
        // R8: pops wrap past top
        run_op(8'hCF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFC, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule